// File: doc/BRIEF.md
# Byte Shuffle and Sign-Apply Unit

This block is a registered 128-bit permute datapath for a packed-integer execution pipe. Each accepted operation takes two operands, A and B, and produces one result vector. Four operations are available: a table shuffle that builds every result byte from a byte of A chosen by a control byte in B, a sign-apply that negates, passes or clears each lane of A according to the sign of the matching lane of B, an absolute value of each signed lane of A, and a byte align that joins A and B into a double-width value and shifts it right by a whole number of bytes.

The lane size for sign-apply and absolute value is 8, 16 or 32 bits. A width select chooses between the full 128-bit form and a 64-bit form. The 64-bit form reads only the low halves of the operands and always returns zero in the upper half of the result. A result appears with its valid flag one clock after the valid input that requested it, and it holds its value until the next accepted operation. Instruction decode and condition flags belong to the surrounding pipe and are not part of this block.

Top module: `byte_permute_unit`

## Requirements
- R1: `outValid` is high in exactly the cycle after a cycle with `inValid` high. `result` changes only on such cycles and otherwise holds its value. Reset (`rst_n` low) clears both `outValid` and `result` to zero.
- R2: Shuffle (`opcode` 0): a result byte is zero whenever bit 7 of the matching control byte of B is set.
- R3: In 128-bit shuffle, when bit 7 of the control byte is clear, bits [3:0] of that byte pick which byte of A is copied (byte 0 is A[7:0]). Bits [6:4] have no effect.
- R4: In 64-bit shuffle (`wide` 0), only control bits [2:0] are used, and they index the eight low bytes of A.
- R5: Sign-apply (`opcode` 1) works lane by lane. A negative B lane gives the two's complement of the A lane, a positive B lane copies the A lane, and a zero B lane gives zero. `elemSize` 0, 1 and 2 select 8-, 16- and 32-bit lanes, and `elemSize` 3 behaves as 2.
- R6: Absolute value (`opcode` 2) writes the magnitude of each signed A lane, using the same lane sizes as R5. The most negative lane value (0x80, 0x8000, 0x80000000) is returned unchanged.
- R7: Align (`opcode` 3, 128-bit): the 256-bit value {A, B}, with A in the upper half, is shifted right by `shiftAmt` bytes, and the low 128 bits are returned.
- R8: In 64-bit align, the 128-bit value {A[63:0], B[63:0]} is shifted right by `shiftAmt` bytes, and its low 64 bits are returned.
- R9: In align, a `shiftAmt` of 32 or more in 128-bit mode, or 16 or more in 64-bit mode, gives a zero result.
- R10: With `wide` 0, result bits [127:64] are zero for every opcode, and operand bits [127:64] have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Operation request strobe |
| opcode | input | 2 | 0 shuffle, 1 sign-apply, 2 absolute value, 3 align |
| elemSize | input | 2 | Lane size: 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit |
| wide | input | 1 | 1 = 128-bit form, 0 = 64-bit form |
| shiftAmt | input | 8 | Byte count for align |
| opA | input | 128 | Source operand A |
| opB | input | 128 | Operand B: control for shuffle and sign-apply, low half of the pair for align |
| outValid | output | 1 | Result valid, one cycle after `inValid` |
| result | output | 128 | Registered result |

## Verification
The assertions check the parts of the behaviour that hold on every cycle:
- the one-cycle valid latency and the hold of the result between operations;
- the zero upper half in the 64-bit form;
- the zeroing from control bit 7 in shuffle byte 0;
- the zeroing from a zero control lane in sign-apply;
- the zero result from an out-of-range align count;
- the rule that an 8-bit absolute value never comes out negative unless it is 0x80.

Only the bench scenarios can show which source byte or lane actually reaches each position. These scenarios cover:
- reversed and repeated shuffle indices, including the ignored bits;
- three-way sign-apply at each lane size, including a zero low byte inside a nonzero 16-bit lane;
- align counts that cross the operand boundary, including the last in-range count;
- recovery after a reset in the middle of a run.

// File: rtl/bpu_pkg.sv
package bpu_pkg;

  localparam logic [1:0] OP_SHUF  = 2'd0;
  localparam logic [1:0] OP_SIGN  = 2'd1;
  localparam logic [1:0] OP_ABS   = 2'd2;
  localparam logic [1:0] OP_ALIGN = 2'd3;

  typedef struct packed {
    logic load;
    logic selShuf;
    logic selSign;
    logic selAbs;
    logic selAlign;
    logic lane16;
    logic lane32;
    logic half;
  } bpuStrobes_t;

endpackage

// File: rtl/bpu_lane.sv
module bpu_lane #(
  parameter int W = 8
) (
  input  logic [W-1:0] src,
  input  logic [W-1:0] ctl,
  output logic [W-1:0] signOut,
  output logic [W-1:0] absOut
);

  logic [W-1:0] negSrc;

  assign negSrc  = ~src + {{(W-1){1'b0}}, 1'b1};
  assign signOut = ctl[W-1] ? negSrc : ((ctl == '0) ? '0 : src);
  assign absOut  = src[W-1] ? negSrc : src;

endmodule

// File: rtl/bpu_ctrl.sv
module bpu_ctrl
  import bpu_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        inValid,
  input  logic [1:0]  opcode,
  input  logic [1:0]  elemSize,
  input  logic        wide,
  output bpuStrobes_t strobes,
  output logic        outValid
);

  always_comb begin
    strobes          = '0;
    strobes.load     = inValid;
    strobes.selShuf  = (opcode == OP_SHUF);
    strobes.selSign  = (opcode == OP_SIGN);
    strobes.selAbs   = (opcode == OP_ABS);
    strobes.selAlign = (opcode == OP_ALIGN);
    strobes.lane32   = elemSize[1];
    strobes.lane16   = (elemSize == 2'd1);
    strobes.half     = !wide;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) outValid <= 1'b0;
    else        outValid <= inValid;
  end

endmodule

// File: rtl/bpu_datapath.sv
module bpu_datapath
  import bpu_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SHIFT_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bpuStrobes_t         strobes,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [SHIFT_W-1:0]  shiftAmt,
  output logic [DATA_W-1:0]   result
);

  localparam int NBYTES = DATA_W / 8;
  localparam int IDX_W  = $clog2(NBYTES);
  localparam int HALF_W = DATA_W / 2;
  localparam int CAT_W  = 2 * DATA_W;
  localparam int NSIZES = 3;

  logic [DATA_W-1:0]             shufRes;
  logic [NSIZES-1:0][DATA_W-1:0] signBy;
  logic [NSIZES-1:0][DATA_W-1:0] absBy;
  logic [DATA_W-1:0]             alignRes;
  logic [DATA_W-1:0]             laneSign;
  logic [DATA_W-1:0]             laneAbs;
  logic [DATA_W-1:0]             modeRes;
  logic [DATA_W-1:0]             nextRes;
  logic [IDX_W-1:0]              idxMask;

  // Table shuffle: one selector per destination byte.
  assign idxMask = strobes.half ? IDX_W'(NBYTES/2 - 1) : IDX_W'(NBYTES - 1);

  for (genvar b = 0; b < NBYTES; b++) begin : g_shuf
    logic [IDX_W-1:0] sel;
    assign sel = opB[b*8 +: IDX_W] & idxMask;
    assign shufRes[b*8 +: 8] = opB[b*8 + 7] ? 8'h00 : opA[sel*8 +: 8];
  end

  // Sign-apply and magnitude lanes for each supported lane width.
  for (genvar s = 0; s < NSIZES; s++) begin : g_size
    localparam int W     = 8 << s;
    localparam int LANES = DATA_W / W;
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      bpu_lane #(.W(W)) u_lane (
        .src    (opA[l*W +: W]),
        .ctl    (opB[l*W +: W]),
        .signOut(signBy[s][l*W +: W]),
        .absOut (absBy[s][l*W +: W])
      );
    end
  end

  always_comb begin
    if (strobes.lane32) begin
      laneSign = signBy[2];
      laneAbs  = absBy[2];
    end else if (strobes.lane16) begin
      laneSign = signBy[1];
      laneAbs  = absBy[1];
    end else begin
      laneSign = signBy[0];
      laneAbs  = absBy[0];
    end
  end

  // Byte align over the concatenated pair.
  logic [CAT_W-1:0]   catPair;
  logic [CAT_W-1:0]   catShift;
  logic [SHIFT_W:0]   limitBytes;
  logic               tooFar;

  assign catPair    = strobes.half ? CAT_W'({opA[HALF_W-1:0], opB[HALF_W-1:0]})
                                   : {opA, opB};
  assign limitBytes = strobes.half ? (SHIFT_W+1)'(NBYTES) : (SHIFT_W+1)'(2*NBYTES);
  assign tooFar     = ({1'b0, shiftAmt} >= limitBytes);
  assign catShift   = catPair >> {shiftAmt, 3'b000};
  assign alignRes   = tooFar ? '0 : catShift[DATA_W-1:0];

  always_comb begin
    if (strobes.selShuf)      modeRes = shufRes;
    else if (strobes.selSign) modeRes = laneSign;
    else if (strobes.selAbs)  modeRes = laneAbs;
    else                      modeRes = alignRes;
  end

  assign nextRes = strobes.half ? {{HALF_W{1'b0}}, modeRes[HALF_W-1:0]} : modeRes;

  always_ff @(posedge clk) begin
    if (!rst_n)            result <= '0;
    else if (strobes.load) result <= nextRes;
  end

endmodule

// File: rtl/byte_permute_unit.sv
module byte_permute_unit
  import bpu_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SHIFT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               inValid,
  input  logic [1:0]         opcode,
  input  logic [1:0]         elemSize,
  input  logic               wide,
  input  logic [SHIFT_W-1:0] shiftAmt,
  input  logic [DATA_W-1:0]  opA,
  input  logic [DATA_W-1:0]  opB,
  output logic               outValid,
  output logic [DATA_W-1:0]  result
);

  bpuStrobes_t strobes;

  bpu_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .inValid (inValid),
    .opcode  (opcode),
    .elemSize(elemSize),
    .wide    (wide),
    .strobes (strobes),
    .outValid(outValid)
  );

  bpu_datapath #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .opA     (opA),
    .opB     (opB),
    .shiftAmt(shiftAmt),
    .result  (result)
  );

endmodule

// File: rtl/bpu_checker.sv
module bpu_checker
  import bpu_pkg::*;
#(
  parameter int DATA_W  = 128,
  parameter int SHIFT_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               inValid,
  input logic [1:0]         opcode,
  input logic [1:0]         elemSize,
  input logic               wide,
  input logic [SHIFT_W-1:0] shiftAmt,
  input logic [DATA_W-1:0]  opA,
  input logic [DATA_W-1:0]  opB,
  input logic               outValid,
  input logic [DATA_W-1:0]  result
);

  localparam int NBYTES = DATA_W / 8;
  localparam int HALF_W = DATA_W / 2;
  localparam logic [SHIFT_W:0] FAR_LIM = (SHIFT_W+1)'(2*NBYTES);

  // R1
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> $stable(result));

  // R2
  shuf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opcode == OP_SHUF && opB[7]) |=> (result[7:0] == 8'h00));

  // R5
  sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opcode == OP_SIGN && elemSize == 2'd2 && opB[31:0] == 32'h0)
      |=> (result[31:0] == 32'h0));

  // R6
  abs_nonneg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opcode == OP_ABS && elemSize == 2'd0)
      |=> (!result[7] || result[7:0] == 8'h80));

  // R9
  align_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && opcode == OP_ALIGN && {1'b0, shiftAmt} >= FAR_LIM)
      |=> (result == '0));

  // R10
  half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !wide) |=> (result[DATA_W-1:HALF_W] == '0));

endmodule

bind byte_permute_unit bpu_checker #(.DATA_W(DATA_W), .SHIFT_W(SHIFT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .inValid (inValid),
  .opcode  (opcode),
  .elemSize(elemSize),
  .wide    (wide),
  .shiftAmt(shiftAmt),
  .opA     (opA),
  .opB     (opB),
  .outValid(outValid),
  .result  (result)
);

// File: tb/byte_permute_unit_tb.sv
`timescale 1ns/1ps
module byte_permute_unit_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         inValid;
  logic [1:0]   opcode;
  logic [1:0]   elemSize;
  logic         wide;
  logic [7:0]   shiftAmt;
  logic [127:0] opA;
  logic [127:0] opB;
  logic         outValid;
  logic [127:0] result;

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  always #2 clk = ~clk;

  byte_permute_unit u_dut (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .opcode(opcode),
    .elemSize(elemSize), .wide(wide), .shiftAmt(shiftAmt),
    .opA(opA), .opB(opB), .outValid(outValid), .result(result)
  );

  typedef struct packed {
    logic [3:0]   req;
    logic [1:0]   op;
    logic [1:0]   es;
    logic         w;
    logic [7:0]   sh;
    logic [127:0] a;
    logic [127:0] b;
    logic [127:0] exp;
  } vec_t;

  localparam logic [127:0] AP = 128'h0f0e0d0c0b0a09080706050403020100;
  localparam logic [127:0] BP = 128'h1f1e1d1c1b1a19181716151413121110;
  localparam int NV = 18;

  localparam vec_t VECS [NV] = '{
    // R3 reversed indices
    '{4'd3, 2'd0, 2'd0, 1'b1, 8'd0, AP, 128'h000102030405060708090a0b0c0d0e0f,
      128'h000102030405060708090a0b0c0d0e0f},
    // R2 zero flag, R3 bits [6:4] ignored
    '{4'd2, 2'd0, 2'd0, 1'b1, 8'd0, AP, 128'h71807180718071807180718071807180,
      128'h01000100010001000100010001000100},
    // R4 64-bit shuffle uses bits [2:0]
    '{4'd4, 2'd0, 2'd0, 1'b0, 8'd0, AP, 128'hffffffffffffffff0d0d0d0d0d0d0d8d,
      128'h00000000000000000505050505050500},
    // R5 8-bit lanes
    '{4'd5, 2'd1, 2'd0, 1'b1, 8'd0, AP, 128'h0000000001010101ffffffff80808080,
      128'h000000000b0a0908f9fafbfcfdfeff00},
    // R5 16-bit lanes
    '{4'd5, 2'd1, 2'd1, 1'b1, 8'd0, AP, 128'hffff7fff00000100ff00000000018000,
      128'hf0f20d0c00000908f8fa00000302ff00},
    // R5 32-bit lanes
    '{4'd5, 2'd1, 2'd2, 1'b1, 8'd0, AP, 128'hffffffff000000000001000080000000,
      128'hf0f1f2f40000000007060504fcfdff00},
    // R5 elemSize 3 acts as 32-bit
    '{4'd5, 2'd1, 2'd3, 1'b1, 8'd0, AP, 128'hffffffff000000000001000080000000,
      128'hf0f1f2f40000000007060504fcfdff00},
    // R6 8-bit magnitude
    '{4'd6, 2'd2, 2'd0, 1'b1, 8'd0, 128'h000000000000000010_81_fe_00_01_7f_ff_80, 128'h0,
      128'h0000000000000000107f0200017f0180},
    // R6 16-bit magnitude
    '{4'd6, 2'd2, 2'd1, 1'b1, 8'd0, 128'h0000000000000000ff800080ffff8000, 128'h0,
      128'h00000000000000000080008000018000},
    // R6 32-bit magnitude
    '{4'd6, 2'd2, 2'd2, 1'b1, 8'd0, 128'h7fffffff00000080fffffffe80000000, 128'h0,
      128'h7fffffff000000800000000280000000},
    // R10 64-bit magnitude ignores upper operand half
    '{4'd10, 2'd2, 2'd0, 1'b0, 8'd0, 128'hffffffffffffffff00000000000080ff, 128'h0,
      128'h00000000000000000000000000008001},
    // R7 shift 4
    '{4'd7, 2'd3, 2'd0, 1'b1, 8'd4, AP, BP, 128'h030201001f1e1d1c1b1a191817161514},
    // R7 shift 20
    '{4'd7, 2'd3, 2'd0, 1'b1, 8'd20, AP, BP, 128'h000000000f0e0d0c0b0a090807060504},
    // R7 shift 31, last in-range count
    '{4'd7, 2'd3, 2'd0, 1'b1, 8'd31, AP, BP, 128'h0000000000000000000000000000000f},
    // R9 shift 32
    '{4'd9, 2'd3, 2'd0, 1'b1, 8'd32, AP, BP, 128'h0},
    // R8 64-bit shift 3
    '{4'd8, 2'd3, 2'd0, 1'b0, 8'd3, AP, BP, 128'h00000000000000000201001716151413},
    // R8 64-bit shift 15
    '{4'd8, 2'd3, 2'd0, 1'b0, 8'd15, AP, BP, 128'h00000000000000000000000000000007},
    // R9 64-bit shift 16
    '{4'd9, 2'd3, 2'd0, 1'b0, 8'd16, AP, BP, 128'h0}
  };

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic issue(logic [1:0] op, logic [1:0] es, logic w, logic [7:0] sh,
                       logic [127:0] a, logic [127:0] b);
    @(negedge clk);
    opcode = op; elemSize = es; wide = w; shiftAmt = sh; opA = a; opB = b;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [127:0] held;
    rst_n = 1'b0; inValid = 1'b0; opcode = '0; elemSize = '0; wide = 1'b1;
    shiftAmt = '0; opA = '0; opB = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 reset outValid", {127'h0, outValid}, 128'h0);
    check("R1 reset result", result, 128'h0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      issue(VECS[i].op, VECS[i].es, VECS[i].w, VECS[i].sh, VECS[i].a, VECS[i].b);
      check($sformatf("R1 valid vec%0d", i), {127'h0, outValid}, 128'h1);
      check($sformatf("R%0d vec%0d", VECS[i].req, i), result, VECS[i].exp);
    end

    // R1 hold: inputs change without valid, result and flag stay put
    held = result;
    @(negedge clk);
    opcode = 2'd0; opA = ~AP; opB = 128'h0;
    repeat (3) @(negedge clk);
    check("R1 hold outValid", {127'h0, outValid}, 128'h0);
    check("R1 hold result", result, held);

    // R9 very large count
    issue(2'd3, 2'd0, 1'b1, 8'd255, AP, BP);
    check("R9 count 255", result, 128'h0);

    // R10 64-bit sign-apply ignores upper operand halves
    issue(2'd1, 2'd2, 1'b0, 8'd0, {64'hdeadbeefcafef00d, 64'h0000000500000007},
          {64'hffffffffffffffff, 64'h0000000000000001});
    check("R10 half sign", result, 128'h00000000000000000000000000000007);

    // R2 R3 all-zero control picks byte 0 everywhere except flagged byte
    issue(2'd0, 2'd0, 1'b1, 8'd0, {120'h0, 8'h5a}, {8'h80, 120'h0});
    check("R2 flagged top byte", result, 128'h005a5a5a5a5a5a5a5a5a5a5a5a5a5a5a);

    // R1 reset mid-run clears the outputs
    issue(2'd0, 2'd0, 1'b1, 8'd0, AP, 128'h0f0e0d0c0b0a09080706050403020100);
    check("R3 identity", result, AP);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid reset result", result, 128'h0);
    check("R1 mid reset outValid", {127'h0, outValid}, 128'h0);
    rst_n = 1'b1;
    issue(2'd2, 2'd0, 1'b1, 8'd0, 128'h0000000000000000000000000000009c, 128'h0);
    check("R6 after reset", result, 128'h00000000000000000000000000000064);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule